// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of an up-counting general-purpose timer. It receives the shared count value and holds a compare value that is written through a small write port. From a three-bit mode code it produces a registered reference waveform and a single-cycle match flag.

The compare value can be written straight into the active register. It can also be staged in a shadow register, which is moved into the active register when the timer sends an update strobe. A trigger strobe can act as an early match when the fast path is enabled. When clearing is enabled, an external level pulls the reference low at once. A nonzero channel-select value turns the channel into an input, and the compare output logic then goes quiet.

Top module: `tim_oc_chan`

## Requirements
- R1: During and after reset, `ref_o` and `match_o` are 0 and the active compare value `cmp_o` is 0.
- R2: Mode code 0 (frozen): `ref_o` keeps its level whatever the count is.
- R3: Mode code 1 drives `ref_o` to 1 one clock after a cycle where `cnt_i` equals the active compare value. Mode code 2 drives it to 0 in the same way. With no match, the level is held.
- R4: Mode code 3 inverts `ref_o` one clock after every cycle in which `cnt_i` equals the active compare value.
- R5: Mode code 4 makes `ref_o` 0 and mode code 5 makes it 1 one clock later, regardless of the count.
- R6: Mode code 6 gives `ref_o` = 1 one clock after a cycle with `cnt_i` < compare value, else 0. Mode code 7 gives the inverse.
- R7: With `preload_en_i` = 0, a write (`cmp_we_i` = 1) sets `cmp_o` to `cmp_wdata_i` on the next clock.
- R8: With `preload_en_i` = 1, a write changes only the shadow. `cmp_o` takes the shadow on a clock where `upd_i` = 1. When `preload_en_i` = 0, `upd_i` has no effect on `cmp_o`.
- R9: With `fast_en_i` = 1, `trig_i` = 1 counts as a match. Modes 1 to 3 act on it, mode 6 goes to 0 and mode 7 goes to 1. With `fast_en_i` = 0, `trig_i` is ignored.
- R10: While `clr_en_i` = 1 and `ext_clr_i` = 1, `ref_o` is 0 in the same cycle and the stored level is cleared. With `clr_en_i` = 0, `ext_clr_i` is ignored.
- R11: `match_o` is 1 for the clock following each cycle in which `cnt_i` equals `cmp_o`, in every mode code.
- R12: While `sel_i` is nonzero, `ref_o` and `match_o` are 0 on the next clock. Mode and match have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Shared timer count |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| mode_i | input | 3 | Compare mode code 0..7 |
| sel_i | input | 2 | Channel direction; 0 = output, else input |
| preload_en_i | input | 1 | Route writes through the shadow register |
| fast_en_i | input | 1 | Trigger acts as compare match |
| clr_en_i | input | 1 | Enable external clearing of the reference |
| trig_i | input | 1 | Trigger event strobe |
| ext_clr_i | input | 1 | External clear level |
| upd_i | input | 1 | Update event strobe |
| cmp_o | output | CNT_W | Active compare value |
| ref_o | output | 1 | Reference waveform |
| match_o | output | 1 | Registered count/compare match flag |

## Verification
The bench builds the channel with an 8-bit count (CNT_W = 8) and keeps the combinational clear overlay on (CLR_COMB = 1). The narrow count lets it drive the count directly to the values that matter: zero, one below the compare value, the compare value itself and far above it. It then checks both PWM polarities around the edge between below and at-or-above. The clear overlay makes the same-cycle effect of the external clear visible at the output.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN   = 3'd0,
    OC_SET      = 3'd1,
    OC_CLR      = 3'd2,
    OC_TOGGLE   = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM1     = 3'd6,
    OC_PWM2     = 3'd7
  } oc_mode_e;
endpackage

// File: rtl/oc_ccr_bank.sv
module oc_ccr_bank #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             preload_en_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) shd_q <= wdata_i;
      // direct write bypasses shadow; update copies only under preload
      if (we_i && !preload_en_i) act_q <= wdata_i;
      else if (upd_i && preload_en_i) act_q <= shd_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/oc_cmp_unit.sv
module oc_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             out_en_i,
  output logic             eq_o,
  output logic             lt_o,
  output logic             match_o
);
  logic match_q;

  assign eq_o = (cnt_i == cmp_i);
  assign lt_o = (cnt_i < cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= eq_o && out_en_i;
  end

  assign match_o = match_q;
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter bit CLR_COMB = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  oc_mode_e mode_i,
  input  logic     out_en_i,
  input  logic     eq_i,
  input  logic     lt_i,
  input  logic     fast_en_i,
  input  logic     trig_i,
  input  logic     clr_en_i,
  input  logic     ext_clr_i,
  output logic     ref_o
);
  logic ref_q, ref_d, fast_hit, hit, clr_now;

  assign fast_hit = fast_en_i && trig_i;
  assign hit      = eq_i || fast_hit;
  assign clr_now  = clr_en_i && ext_clr_i;

  always_comb begin
    ref_d = ref_q;
    if (!out_en_i || clr_now) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode_i)
        OC_FROZEN:   ref_d = ref_q;
        OC_SET:      if (hit) ref_d = 1'b1;
        OC_CLR:      if (hit) ref_d = 1'b0;
        OC_TOGGLE:   if (hit) ref_d = ~ref_q;
        OC_FORCE_LO: ref_d = 1'b0;
        OC_FORCE_HI: ref_d = 1'b1;
        OC_PWM1:     ref_d = fast_hit ? 1'b0 :  lt_i;
        OC_PWM2:     ref_d = fast_hit ? 1'b1 : ~lt_i;
        default:     ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  generate
    if (CLR_COMB) begin : g_clr_comb
      assign ref_o = ref_q && !clr_now;
    end else begin : g_clr_reg
      assign ref_o = ref_q;
    end
  endgenerate
endmodule

// File: rtl/tim_oc_chan.sv
module tim_oc_chan
  import oc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit CLR_COMB = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       sel_i,
  input  logic             preload_en_i,
  input  logic             fast_en_i,
  input  logic             clr_en_i,
  input  logic             trig_i,
  input  logic             ext_clr_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             ref_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cmp_act;
  logic             out_en, eq, lt;
  oc_mode_e         mode;

  assign out_en = (sel_i == 2'd0);
  assign mode   = oc_mode_e'(mode_i);

  oc_ccr_bank #(.CNT_W(CNT_W)) u_ccr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cmp_we_i),
    .wdata_i     (cmp_wdata_i),
    .preload_en_i(preload_en_i),
    .upd_i       (upd_i),
    .act_o       (cmp_act)
  );

  oc_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .cmp_i   (cmp_act),
    .out_en_i(out_en),
    .eq_o    (eq),
    .lt_o    (lt),
    .match_o (match_o)
  );

  oc_ref_gen #(.CLR_COMB(CLR_COMB)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .out_en_i (out_en),
    .eq_i     (eq),
    .lt_i     (lt),
    .fast_en_i(fast_en_i),
    .trig_i   (trig_i),
    .clr_en_i (clr_en_i),
    .ext_clr_i(ext_clr_i),
    .ref_o    (ref_o)
  );

  assign cmp_o = cmp_act;
endmodule

// File: rtl/tim_oc_chan_chk.sv
module tim_oc_chan_chk #(
  parameter int CNT_W    = 16,
  parameter bit CLR_COMB = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cmp_we_i,
  input logic [CNT_W-1:0] cmp_wdata_i,
  input logic [2:0]       mode_i,
  input logic [1:0]       sel_i,
  input logic             preload_en_i,
  input logic             fast_en_i,
  input logic             clr_en_i,
  input logic             trig_i,
  input logic             ext_clr_i,
  input logic             upd_i,
  input logic [CNT_W-1:0] cmp_o,
  input logic             ref_o,
  input logic             match_o
);
  logic out_en, clr_now, eq;
  assign out_en  = (sel_i == 2'd0);
  assign clr_now = clr_en_i && ext_clr_i;
  assign eq      = (cnt_i == cmp_o);

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en && mode_i == 3'd0 && !clr_now) |=> (ref_o == $past(ref_o)) || clr_now) // R2
    else $error("frozen level changed");

  AST_SET_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en && mode_i == 3'd1 && eq && !clr_now) |=> ref_o || clr_now) // R3
    else $error("set on match missed");

  AST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en && mode_i == 3'd3 && eq && !clr_now) |=> (ref_o != $past(ref_o)) || clr_now) // R4
    else $error("toggle missed");

  AST_FORCE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en && mode_i == 3'd5 && !clr_now) |=> ref_o || clr_now) // R5
    else $error("force high failed");

  AST_PWM1_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en && mode_i == 3'd6 && !(fast_en_i && trig_i) && !clr_now)
      |=> (ref_o == $past(cnt_i < cmp_o)) || clr_now) // R6
    else $error("pwm1 level wrong");

  AST_DIRECT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && !preload_en_i) |=> cmp_o == $past(cmp_wdata_i)) // R7
    else $error("direct write lost");

  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_we_i && !(upd_i && preload_en_i)) |=> $stable(cmp_o)) // R8
    else $error("compare value moved without cause");

  AST_MATCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en && eq) |=> match_o) // R11
    else $error("match flag missed");

  AST_INPUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en |=> !ref_o && !match_o) // R12
    else $error("output active in input mode");

  generate
    if (CLR_COMB) begin : g_chk_comb
      always_comb begin
        if (rst_ni && clr_now) begin
          AST_CLEAR_NOW: assert (!ref_o) else $error("clear not immediate"); // R10
        end
      end
    end else begin : g_chk_reg
      AST_CLEAR_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_now |=> !ref_o || !$past(clr_now)) // R10
        else $error("clear not applied");
    end
  endgenerate
endmodule

bind tim_oc_chan tim_oc_chan_chk #(.CNT_W(CNT_W), .CLR_COMB(CLR_COMB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_i       (cnt_i),
  .cmp_we_i    (cmp_we_i),
  .cmp_wdata_i (cmp_wdata_i),
  .mode_i      (mode_i),
  .sel_i       (sel_i),
  .preload_en_i(preload_en_i),
  .fast_en_i   (fast_en_i),
  .clr_en_i    (clr_en_i),
  .trig_i      (trig_i),
  .ext_clr_i   (ext_clr_i),
  .upd_i       (upd_i),
  .cmp_o       (cmp_o),
  .ref_o       (ref_o),
  .match_o     (match_o)
);

// File: tb/tim_oc_chan_tb.sv
module tim_oc_chan_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0, wdata = '0, cmp;
  logic         we = 0, pre = 0, fast = 0, clren = 0, trig = 0, xclr = 0, upd = 0;
  logic [2:0]   mode = 3'd0;
  logic [1:0]   sel = 2'd0;
  logic         ref_s, match_s;
  int           checks = 0, errors = 0;

  typedef struct {
    int req;
    int e_ref;
    int e_match;
    int e_cmp;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  tim_oc_chan #(.CNT_W(W), .CLR_COMB(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cmp_we_i(we), .cmp_wdata_i(wdata),
    .mode_i(mode), .sel_i(sel), .preload_en_i(pre), .fast_en_i(fast),
    .clr_en_i(clren), .trig_i(trig), .ext_clr_i(xclr), .upd_i(upd),
    .cmp_o(cmp), .ref_o(ref_s), .match_o(match_s)
  );

  task automatic chk(int req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: inputs set before the call; expectation is for after the next edge, -1 = don't care
  task automatic step(int req, int r, int m, int c);
    item_t it;
    it.req = req; it.e_ref = r; it.e_match = m; it.e_cmp = c;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.e_ref   >= 0) chk(it.req, "ref",   int'(ref_s),   it.e_ref);
        if (it.e_match >= 0) chk(it.req, "match", int'(match_s), it.e_match);
        if (it.e_cmp   >= 0) chk(it.req, "cmp",   int'(cmp),     it.e_cmp);
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #25;
    // R1 reset state
    chk(1, "ref", int'(ref_s), 0);
    chk(1, "match", int'(match_s), 0);
    chk(1, "cmp", int'(cmp), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 direct write
    we = 1; wdata = 8'd5; step(7, 0, -1, 5);
    we = 0;
    // R2 frozen, R11 match in frozen mode
    cnt = 8'd5; step(11, 0, 1, 5);
    cnt = 8'd6; step(11, 0, 0, -1);
    // R3 set on match
    mode = 3'd1; cnt = 8'd4; step(3, 0, 0, -1);
    cnt = 8'd5; step(3, 1, 1, -1);
    cnt = 8'd6; step(3, 1, 0, -1);
    mode = 3'd0; cnt = 8'd5; step(2, 1, 1, -1);   // frozen holds high
    mode = 3'd2; cnt = 8'd6; step(3, 1, 0, -1);
    cnt = 8'd5; step(3, 0, 1, -1);
    // R4 toggle
    mode = 3'd3; step(4, 1, 1, -1);
    step(4, 0, 1, -1);
    cnt = 8'd7; step(4, 0, 0, -1);
    cnt = 8'd5; step(4, 1, 1, -1);
    // R5 force
    mode = 3'd4; step(5, 0, 1, -1);
    mode = 3'd5; cnt = 8'd9; step(5, 1, 0, -1);
    // R6 pwm
    mode = 3'd6; cnt = 8'd4; step(6, 1, 0, -1);
    cnt = 8'd5; step(6, 0, 1, -1);
    cnt = 8'd200; step(6, 0, 0, -1);
    cnt = 8'd0; step(6, 1, 0, -1);
    mode = 3'd7; cnt = 8'd4; step(6, 0, 0, -1);
    cnt = 8'd5; step(6, 1, 1, -1);
    // R8 preload shadow
    mode = 3'd0; cnt = 8'd0;
    pre = 1; we = 1; wdata = 8'd20; step(8, -1, -1, 5);
    we = 0; step(8, -1, -1, 5);
    upd = 1; step(8, -1, -1, 20);
    upd = 0; we = 1; wdata = 8'd30; step(8, -1, -1, 20);
    we = 0; pre = 0; upd = 1; step(8, -1, -1, 20);
    pre = 1; step(8, -1, -1, 30);
    upd = 0; pre = 0;
    // R9 fast trigger
    mode = 3'd4; step(9, 0, 0, 30);
    mode = 3'd1; trig = 1; fast = 0; step(9, 0, 0, -1);
    fast = 1; step(9, 1, 0, -1);
    mode = 3'd2; step(9, 0, 0, -1);
    trig = 0; mode = 3'd6; step(9, 1, 0, -1);
    trig = 1; step(9, 0, 0, -1);
    mode = 3'd7; step(9, 1, 0, -1);
    trig = 0; fast = 0;
    // R10 external clear
    mode = 3'd5; xclr = 1; clren = 0; step(10, 1, 0, -1);
    clren = 1; step(10, 0, 0, -1);
    step(10, 0, 0, -1);
    xclr = 0; step(10, 1, 0, -1);
    clren = 0;
    // R12 input select
    sel = 2'd1; cnt = 8'd30; step(12, 0, 0, -1);
    sel = 2'd3; mode = 3'd3; step(12, 0, 0, -1);
    sel = 2'd0; mode = 3'd5; step(12, 1, 1, -1);

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule